// File: doc/BRIEF.md
# Bitwise Rank Selector

This block returns the k-th largest entry of a table of N unsigned values. It never sorts, swaps or compares entries with each other. It builds its answer one bit at a time, from the most significant bit down to bit 0, using successive approximation. For each bit it tries a threshold equal to the current candidate with that bit added. It then reads the whole table once and counts how many entries reach that threshold. If the count is at least k, the bit stays set in the candidate.

The table sits outside the block and is read through a simple address/data port. The block only reads it and never writes to it. Setting k to 1 gives the maximum, k equal to N gives the minimum, and k equal to ceil(N/2) gives the median. Each entry also has a keep bit. Entries whose keep bit is clear take part in no count, which turns the search into a conditional rank query over a subset of the table.

Top module: `kth_select`

## Requirements
- R1: After reset, `done`, `err` and `busy` are 0 and `result` is 0.
- R2: For a valid request, `result` equals the k-th largest value among the counted entries at addresses 0 to N-1. Equal values count once per entry, as in a list sorted in descending order.
- R3: k = 1 returns the largest counted value and k = N returns the smallest counted value.
- R4: Each bit step uses the threshold candidate + 2^i, where i runs from DATA_W-1 down to 0. Bit i is kept when at least k counted entries are greater than or equal to that threshold. The threshold never carries out of DATA_W bits.
- R5: A valid request raises `done` exactly DATA_W*N clock cycles after the edge that accepts `start`. `busy` is high for exactly those cycles and is never high together with `done`.
- R6: While `busy` is high, `rd_addr` steps 0, 1, ..., N-1 once per cycle and then wraps to 0. There is one such pass for each bit, so address N-1 is presented exactly DATA_W times per request.
- R7: If k = 0, N = 0, N > DEPTH or k > N, the block raises `done` and `err` one cycle after `start` (latency 0 counted from the accepting edge) and gives `result` = 0.
- R8: An entry whose `rd_keep` bit is 0 is left out of every count. If fewer than k entries are kept, `result` is 0 and `err` is 0.
- R9: A `start` pulse while `busy` is high is ignored. The running request finishes with its own k, N and its own latency.
- R10: `done` is a one-cycle pulse. `result` and `err` change only in the cycle in which `done` is high, and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| k_in | input | CNT_W | Rank to find, 1 = largest |
| n_in | input | CNT_W | Number of table entries used |
| rd_addr | output | ADDR_W | Table read address |
| rd_data | input | DATA_W | Table value at `rd_addr`, same cycle |
| rd_keep | input | 1 | Keep bit at `rd_addr`, 0 excludes the entry |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was invalid |
| result | output | DATA_W | k-th largest counted value |

## Verification
The hardest cases to reach from the ports are those where the rank lands inside a run of equal values, and those where the keep bits shrink the counted set below k. In both, the count for some bit sits exactly at the k boundary. The stimulus table therefore holds a duplicated value ranked from both sides, a table split evenly between 0 and 255, and masks that remove the maximum or leave fewer kept entries than the requested rank. A start pulse is also driven part-way through a pass, with a different rank, to show it has no effect on the result or the timing.

// File: rtl/kth_pkg.sv
package kth_pkg;
   typedef enum logic [0:0] {
      KS_IDLE = 1'b0,
      KS_SCAN = 1'b1
   } ks_state_e;
endpackage

// File: rtl/kth_trial.sv
module kth_trial #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0] cand,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] thresh,
   output logic              carry
);
   logic [DATA_W:0] step;
   logic [DATA_W:0] sum;

   always_comb begin
      step   = (DATA_W+1)'(1) << idx;
      sum    = {1'b0, cand} + step;
      thresh = sum[DATA_W-1:0];
      carry  = sum[DATA_W];
   end
endmodule

// File: rtl/kth_counter.sv
module kth_counter #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 5,
   parameter bit USE_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              first,
   input  logic [DATA_W-1:0] value,
   input  logic              keep,
   input  logic [DATA_W-1:0] thresh,
   input  logic              carry,
   output logic [CNT_W-1:0]  count_next
);
   logic [CNT_W-1:0] count_q;
   logic             keep_eff;
   logic             hit;

   generate
      if (USE_MASK) begin : g_mask
         assign keep_eff = keep;
      end else begin : g_nomask
         logic keep_unused;
         assign keep_unused = keep;
         assign keep_eff    = 1'b1;
      end
   endgenerate

   assign hit        = en && keep_eff && !carry && (value >= thresh);
   assign count_next = (first ? '0 : count_q) + CNT_W'(hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  count_q <= '0;
      else if (en) count_q <= count_next;
   end
endmodule

// File: rtl/kth_ctrl.sv
module kth_ctrl
   import kth_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5,
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  k_in,
   input  logic [CNT_W-1:0]  n_in,
   input  logic [CNT_W-1:0]  count_next,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] cand,
   output logic [IDX_W-1:0]  idx,
   output logic              scan,
   output logic              first,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] result
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W-1);

   ks_state_e        state;
   logic [CNT_W-1:0] k_q;
   logic [CNT_W-1:0] n_q;
   logic             last;
   logic             bad_req;
   logic             keep_bit;
   logic [DATA_W-1:0] cand_upd;

   assign scan     = (state == KS_SCAN);
   assign first    = scan && (addr == '0);
   assign last     = (CNT_W'(addr) + CNT_W'(1)) == n_q;
   assign bad_req  = (k_in == '0) || (n_in == '0) || (n_in > CNT_W'(DEPTH)) || (k_in > n_in);
   assign keep_bit = count_next >= k_q;
   assign cand_upd = keep_bit ? (cand | (DATA_W'(1) << idx)) : cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= KS_IDLE;
         k_q    <= '0;
         n_q    <= '0;
         addr   <= '0;
         cand   <= '0;
         idx    <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            KS_IDLE: begin
               if (start) begin
                  if (bad_req) begin
                     done   <= 1'b1;
                     err    <= 1'b1;
                     result <= '0;
                  end else begin
                     k_q   <= k_in;
                     n_q   <= n_in;
                     addr  <= '0;
                     cand  <= '0;
                     idx   <= TOP_IDX;
                     state <= KS_SCAN;
                  end
               end
            end
            KS_SCAN: begin
               if (last) begin
                  addr <= '0;
                  cand <= cand_upd;
                  if (idx == '0) begin
                     result <= cand_upd;
                     err    <= 1'b0;
                     done   <= 1'b1;
                     state  <= KS_IDLE;
                  end else begin
                     idx <= idx - IDX_W'(1);
                  end
               end else begin
                  addr <= addr + ADDR_W'(1);
               end
            end
            default: state <= KS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/kth_select.sv
module kth_select #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter bit USE_MASK = 1'b1,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  k_in,
   input  logic [CNT_W-1:0]  n_in,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_keep,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] result
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("kth_select: DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("kth_select: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] cand;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] thresh;
   logic              trial_carry;
   logic              first;
   logic [CNT_W-1:0]  count_next;

   kth_trial #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_trial (
      .cand   (cand),
      .idx    (idx),
      .thresh (thresh),
      .carry  (trial_carry)
   );

   kth_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W), .USE_MASK(USE_MASK)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (busy),
      .first      (first),
      .value      (rd_data),
      .keep       (rd_keep),
      .thresh     (thresh),
      .carry      (trial_carry),
      .count_next (count_next)
   );

   kth_ctrl #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
      .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .k_in       (k_in),
      .n_in       (n_in),
      .count_next (count_next),
      .addr       (rd_addr),
      .cand       (cand),
      .idx        (idx),
      .scan       (busy),
      .first      (first),
      .done       (done),
      .err        (err),
      .result     (result)
   );
endmodule

// File: rtl/kth_select_chk.sv
module kth_select_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] result,
   input logic              carry
);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(err)));

   assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (result == '0));

   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_addr != '0) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

   assert_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !carry);

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind kth_select kth_select_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .rd_addr (rd_addr),
   .result  (result),
   .carry   (trial_carry)
);

// File: tb/kth_select_bench.sv
module kth_select_bench;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int ADDR_W = $clog2(DEPTH);

   typedef struct packed {
      logic [63:0] vals;
      logic [7:0]  keep;
      logic [4:0]  n;
      logic [4:0]  k;
      logic [7:0]  exp;
      logic        exp_err;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VEC [NVEC] = '{
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd1, 8'd232, 1'b0},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd8, 8'd10,  1'b0},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd4, 8'd192, 1'b0},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd3, 8'd200, 1'b0},
      '{64'hE8C8C8C06325180A, 8'h7F, 5'd8, 5'd1, 8'd200, 1'b0},
      '{64'hE8C8C8C06325180A, 8'h0F, 5'd8, 5'd2, 8'd37,  1'b0},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd5, 5'd5, 8'd10,  1'b0},
      '{64'hFF00FF00FF00FF00, 8'hFF, 5'd8, 5'd5, 8'd0,   1'b0},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd0, 8'd0,   1'b1},
      '{64'hE8C8C8C06325180A, 8'hFF, 5'd8, 5'd9, 8'd0,   1'b1},
      '{64'hE8C8C8C06325180A, 8'h03, 5'd8, 5'd3, 8'd0,   1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  k_in = '0;
   logic [CNT_W-1:0]  n_in = '0;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              rd_keep;
   logic              busy, done, err;
   logic [DATA_W-1:0] result;

   logic [DATA_W-1:0] mem  [DEPTH];
   logic              keep [DEPTH];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign rd_data = mem[rd_addr];
   assign rd_keep = keep[rd_addr];

   kth_select u_kth_select (
      .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .n_in(n_in),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_keep(rd_keep),
      .busy(busy), .done(done), .err(err), .result(result)
   );

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic load(input logic [63:0] vals, input logic [7:0] kp);
      for (int j = 0; j < DEPTH; j++) begin
         mem[j]  = (j < 8) ? vals[8*j +: 8] : 8'd0;
         keep[j] = (j < 8) ? kp[j] : 1'b0;
      end
   endtask

   // Runs one request; optionally pulses start again mid-run (R9).
   task automatic run(input vec_t v, input bit poke, input string tag);
      int lat;
      int hits;
      load(v.vals, v.keep);
      @(negedge clk);
      k_in  = CNT_W'(v.k);
      n_in  = CNT_W'(v.n);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat  = 0;
      hits = 0;
      while (!done && lat < 2000) begin
         if (busy && (int'(rd_addr) == int'(v.n) - 1)) hits++;
         if (poke && lat == 10) begin
            k_in  = CNT_W'(8);
            start = 1'b1;
         end
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      check({tag, " R2 result"}, int'(result), int'(v.exp));
      check({tag, " R7 err"}, int'(err), int'(v.exp_err));
      check({tag, " R5 latency"}, lat, v.exp_err ? 0 : DATA_W * int'(v.n));
      if (!v.exp_err) check({tag, " R6 last-address visits"}, hits, DATA_W);
      @(posedge clk);
      @(negedge clk);
      check({tag, " R10 done pulse"}, int'(done), 0);
      check({tag, " R10 result hold"}, int'(result), int'(v.exp));
   endtask

   initial begin
      wait (cyc >= 150000);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      load(64'h0, 8'h0);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done", int'(done), 0);
      check("R1 err", int'(err), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 result", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table: R2/R4 max trace, R3 min, median, duplicates, R8 masks, R7 invalid
      for (int i = 0; i < NVEC; i++) begin
         run(VEC[i], 1'b0, $sformatf("vec%0d", i));
      end

      // R3: max and min of the same table again after an error request
      run(VEC[0], 1'b0, "R3 max");
      run(VEC[1], 1'b0, "R3 min");

      // R9: start with k=8 mid-run must not disturb k=1 request
      run(VEC[0], 1'b1, "R9 start ignored");

      // R7: N beyond DEPTH and N = 0
      run('{64'h0, 8'hFF, 5'd17, 5'd1, 8'd0, 1'b1}, 1'b0, "R7 n>depth");
      run('{64'h0, 8'hFF, 5'd0,  5'd0, 8'd0, 1'b1}, 1'b0, "R7 n=0");

      // R8: only two kept entries, rank 2 gives the smaller of them
      run('{64'hE8C8C8C06325180A, 8'h90, 5'd8, 5'd2, 8'd192, 1'b0}, 1'b0, "R8 sparse mask");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule